// File: doc/BRIEF.md
# Zero-Count Check-Symbol Encoder and Dual-Rail Checker

This block protects a data word against unidirectional errors by attaching a check symbol equal to the number of zero bits in the word. Its encode side takes a `K`-bit data word and returns the codeword: the unchanged data in the upper bits, followed by the zero count in the low bits. Its check side takes a received data word and a received check symbol, recounts the zeros, and compares the two.

An error in which bits only fall from 1 to 0 raises the zero count of the data, but it can only lower the received symbol. An error in which bits only rise from 0 to 1 does the opposite. The recount and the symbol can therefore never agree after such an error, whatever its multiplicity. The comparison result leaves the block on two wires. A differing pair means the word is clean, and an equal pair means an error, so a single stuck output wire cannot pass for a clean result.

Both results are registered. A shared valid strobe qualifies both sides, and the outputs hold their values while the strobe is low.

Top module: `berger_codec`

## Requirements
- R1: The check symbol is C = ceil(log2(K+1)) bits wide (K=7 gives 3, K=8 gives 4, K=3 gives 2), and its value never exceeds K.
- R2: One clock after a cycle with `valid_i` high, `enc_word_o[C-1:0]` holds the number of 0 bits in the `enc_data_i` sampled in that cycle, as an unsigned binary value.
- R3: One clock after a cycle with `valid_i` high, `enc_word_o[K+C-1:C]` equals the `enc_data_i` sampled in that cycle, bit for bit.
- R4: On a checked cycle whose recount equals `chk_sym_i`, `err_rail_o` becomes 2'b10 or 2'b01. On a checked cycle whose recount differs, it becomes 2'b00 or 2'b11.
- R5: A phase bit, cleared by reset, flips on every checked cycle. With phase 0 a clean result is 2'b10 and an error is 2'b00. With phase 1 a clean result is 2'b01 and an error is 2'b11. Consecutive clean words therefore alternate 10, 01, 10, and so on.
- R6: Any nonzero unidirectional corruption of a valid codeword, applied across data and check bits together, yields an error pair (00 or 11).
- R7: While `valid_i` is low, `enc_word_o` and `err_rail_o` keep their values, whatever the data inputs do.
- R8: While `rst_n` is low at a clock edge, `enc_word_o` becomes all zeros and `err_rail_o` becomes 2'b01.
- R9: With K=3 the eight codewords, in the order of the messages 000 to 111, are 00011, 00110, 01010, 01101, 10010, 10101, 11001 and 11100.
- R10: With K=7, data 1000101 encodes to codeword 1000101_100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Qualifies both the encode and the check inputs in this cycle |
| enc_data_i | input | K | Data word to encode |
| chk_data_i | input | K | Received data word to check |
| chk_sym_i | input | C | Received check symbol belonging to `chk_data_i` |
| enc_word_o | output | K+C | Registered codeword: data in the upper bits, zero count in the low bits |
| err_rail_o | output | 2 | Registered dual-rail check result (differing pair means clean, equal pair means error) |

## Verification
On every clock the assertions check four things: the codeword's data field follows the sampled input, the symbol stays within range, an idle strobe holds both outputs, and the rail pair's class (differing or equal) agrees with the recount comparison. They also check that back-to-back clean words flip the rail pair. The exact zero counts, the exhaustive K=3 codeword set, the K=7 example and the exact rail phase sequence come only from the bench scenarios. Detection of random multi-bit one-direction corruptions also comes only from the bench, which compares against its own model.

// File: rtl/berger_pkg.sv
// Package: shared sizing helper for the zero-count check code.
// Assumes the data width is at least 2 bits.
package berger_pkg;
    // Width of a binary count able to hold the values 0..k.
    function automatic int chk_width(input int k);
        return $clog2(k + 1);
    endfunction
endpackage

// File: rtl/berger_zero_count.sv
// Module: berger_zero_count
// Counts the 0 bits of a K-bit word and returns the count in C bits.
// Purely combinational; assumes C is wide enough to hold the value K.
module berger_zero_count #(
    parameter int K = 8,
    parameter int C = berger_pkg::chk_width(K)
) (
    input  logic [K-1:0] data_i,
    output logic [C-1:0] zeros_o
);
    // Sum the inverted data bits into the count.
    always_comb begin
        zeros_o = '0;
        for (int i = 0; i < K; i++) begin
            zeros_o = zeros_o + C'(!data_i[i]);
        end
    end
endmodule

// File: rtl/berger_rail_reg.sv
// Module: berger_rail_reg
// Registers a pass/fail result as a dual-rail pair whose polarity
// alternates with a phase bit that flips on every qualified cycle.
// Assumes pass_i is only meaningful when valid_i is high.
module berger_rail_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid_i,
    input  logic       pass_i,
    output logic [1:0] rail_o
);
    logic phase_q;

    // Phase bit: cleared by reset, flips on every checked cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= 1'b0;
        else if (valid_i) phase_q <= ~phase_q;
    end

    // Rail pair: differing when clean, equal when failing, polarity set by phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       rail_o <= 2'b01;
        else if (valid_i) rail_o <= pass_i ? {~phase_q, phase_q} : {phase_q, phase_q};
    end

    // R5
    rail_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pass_i && $past(valid_i && pass_i)) |=> (rail_o != $past(rail_o)));
endmodule

// File: rtl/berger_codec.sv
// Module: berger_codec (top)
// Encodes a data word with its zero-count check symbol and checks a
// received word/symbol pair, both registered under a shared valid strobe.
// Assumes K >= 2; outputs hold when valid_i is low.
module berger_codec #(
    parameter int K = 8,
    localparam int C = berger_pkg::chk_width(K),
    localparam int W = K + C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [K-1:0] enc_data_i,
    input  logic [K-1:0] chk_data_i,
    input  logic [C-1:0] chk_sym_i,
    output logic [W-1:0] enc_word_o,
    output logic [1:0]   err_rail_o
);
    logic [C-1:0] enc_zeros;
    logic [C-1:0] chk_zeros;
    logic         chk_pass;

    berger_zero_count #(.K(K), .C(C)) u_enc_cnt (
        .data_i (enc_data_i),
        .zeros_o(enc_zeros)
    );

    berger_zero_count #(.K(K), .C(C)) u_chk_cnt (
        .data_i (chk_data_i),
        .zeros_o(chk_zeros)
    );

    // Compare the recount with the received symbol.
    always_comb chk_pass = (chk_zeros == chk_sym_i);

    // Codeword register: data above, zero count below.
    always_ff @(posedge clk) begin
        if (!rst_n)       enc_word_o <= '0;
        else if (valid_i) enc_word_o <= {enc_data_i, enc_zeros};
    end

    berger_rail_reg u_rail (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(valid_i),
        .pass_i (chk_pass),
        .rail_o (err_rail_o)
    );

    // R3
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (enc_word_o[W-1:C] == $past(enc_data_i)));

    // R1
    sym_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_word_o[C-1:0] <= C'(K));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(enc_word_o) && $stable(err_rail_o)));

    // R4
    rail_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (chk_zeros == chk_sym_i)) |=> (err_rail_o[0] != err_rail_o[1]));

    // R4
    rail_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (chk_zeros != chk_sym_i)) |=> (err_rail_o[0] == err_rail_o[1]));
endmodule

// File: tb/tb_berger_codec.sv
module tb_berger_codec;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vld = 1'b0;

    logic [7:0]  e8 = '0, c8 = '0;
    logic [3:0]  s8 = '0;
    logic [11:0] w8;
    logic [1:0]  r8;

    logic [2:0]  e3 = '0, c3 = '0;
    logic [1:0]  s3 = '0;
    logic [4:0]  w3;
    logic [1:0]  r3;

    logic [6:0]  e7 = '0, c7 = '0;
    logic [2:0]  s7 = '0;
    logic [9:0]  w7;
    logic [1:0]  r7;

    int n_cmp = 0;
    int n_bad = 0;
    bit ph = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    berger_codec #(.K(8)) dut (.clk(clk), .rst_n(rst_n), .valid_i(vld),
        .enc_data_i(e8), .chk_data_i(c8), .chk_sym_i(s8), .enc_word_o(w8), .err_rail_o(r8));
    berger_codec #(.K(3)) dut_k3 (.clk(clk), .rst_n(rst_n), .valid_i(vld),
        .enc_data_i(e3), .chk_data_i(c3), .chk_sym_i(s3), .enc_word_o(w3), .err_rail_o(r3));
    berger_codec #(.K(7)) dut_k7 (.clk(clk), .rst_n(rst_n), .valid_i(vld),
        .enc_data_i(e7), .chk_data_i(c7), .chk_sym_i(s7), .enc_word_o(w7), .err_rail_o(r7));

    function automatic int zc(input logic [31:0] d, input int k);
        int n = 0;
        for (int i = 0; i < k; i++) if (!d[i]) n++;
        return n;
    endfunction

    function automatic logic [1:0] exp_rail(input bit ok, input bit p);
        return ok ? (p ? 2'b01 : 2'b10) : (p ? 2'b11 : 2'b00);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply a valid cycle: inputs are set by the caller at a negedge.
    task automatic step_valid();
        vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [4:0] k3_set [8];
        k3_set = '{5'b00011, 5'b00110, 5'b01010, 5'b01101,
                   5'b10010, 5'b10101, 5'b11001, 5'b11100};
        void'($urandom(32'h5EED));

        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 word", 32'(w8), 32'h0);
        chk("R8 rail", 32'(r8), 32'h1);
        rst_n = 1'b1;

        // R10 / R1: K=7 example
        e7 = 7'b1000101;
        c7 = 7'b1000101; s7 = 3'b100;
        e8 = '0; c8 = '0; s8 = 4'd8;
        step_valid();
        chk("R10 codeword", 32'(w7), 32'(10'b1000101_100));
        chk("R1 k7 symbol", 32'(w7[2:0]), 32'd4);
        chk("R1 k8 all-zero symbol", 32'(w8[3:0]), 32'd8);
        chk("R4 clean rail", 32'(r8), 32'(exp_rail(1'b1, ph)));
        ph = ~ph;

        // R9: exhaustive K=3 codewords, checker fed the same codewords
        for (int m = 0; m < 8; m++) begin
            e3 = 3'(m);
            c3 = k3_set[m][4:2]; s3 = k3_set[m][1:0];
            c8 = 8'hFF; s8 = 4'd0;
            step_valid();
            chk("R9 k3 codeword", 32'(w3), 32'(k3_set[m]));
            chk("R4 k3 clean class", 32'(r3[0] ^ r3[1]), 32'd1);
            chk("R5 rail phase", 32'(r8), 32'(exp_rail(1'b1, ph)));
            ph = ~ph;
        end

        // R2 R3 R5: random encodes with clean checks, including all-ones/zeros
        for (int t = 0; t < 60; t++) begin
            logic [7:0] d;
            d = (t == 0) ? 8'hFF : (t == 1) ? 8'h00 : 8'($urandom);
            e8 = d;
            c8 = ~d; s8 = 4'(zc(32'(~d), 8));
            step_valid();
            chk("R3 data field", 32'(w8[11:4]), 32'(d));
            chk("R2 zero count", 32'(w8[3:0]), 32'(zc(32'(d), 8)));
            chk("R5 clean alternation", 32'(r8), 32'(exp_rail(1'b1, ph)));
            ph = ~ph;
        end

        // R6 R4: unidirectional corruptions in both directions
        for (int t = 0; t < 80; t++) begin
            logic [7:0]  d;
            logic [11:0] cw, bad, mask;
            d = 8'($urandom);
            cw = {d, 4'(zc(32'(d), 8))};
            mask = 12'($urandom);
            if (t < 3) mask = 12'hFFF;
            bad = t[0] ? (cw | mask) : (cw & ~mask);
            if (bad == cw) continue;
            e8 = d;
            c8 = bad[11:4]; s8 = bad[3:0];
            step_valid();
            chk("R6 unidirectional error", 32'(r8), 32'(exp_rail(1'b0, ph)));
            ph = ~ph;
        end

        // R4: a bidirectional swap that keeps the count is clean (data 01 -> 10)
        c8 = 8'b0000_0010; s8 = 4'd7;
        step_valid();
        chk("R4 clean after error", 32'(r8), 32'(exp_rail(1'b1, ph)));
        ph = ~ph;

        // R7: outputs hold while valid is low
        begin
            logic [11:0] w_hold;
            logic [1:0]  r_hold;
            w_hold = w8; r_hold = r8;
            for (int t = 0; t < 5; t++) begin
                e8 = 8'($urandom); c8 = 8'($urandom); s8 = 4'($urandom);
                @(negedge clk);
                chk("R7 word held", 32'(w8), 32'(w_hold));
                chk("R7 rail held", 32'(r8), 32'(r_hold));
            end
        end

        // R5: phase continues after idle cycles
        e8 = 8'h0F; c8 = 8'h0F; s8 = 4'd3;
        step_valid();
        chk("R5 mismatch after idle", 32'(r8), 32'(exp_rail(1'b0, ph)));
        ph = ~ph;

        // R8: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 word after reset", 32'(w8), 32'h0);
        chk("R8 rail after reset", 32'(r8), 32'h1);
        rst_n = 1'b1;
        ph = 1'b0;
        c8 = 8'h0F; s8 = 4'd4;
        step_valid();
        chk("R5 first phase after reset", 32'(r8), 32'(exp_rail(1'b1, ph)));

        finish_run();
    end
endmodule